// File: doc/BRIEF.md
# Remote Wake-Up Frame Detector

The block inspects a received Ethernet frame one byte at a time and decides whether the frame asks the station to wake up. It searches anywhere in the frame for a sync run of six 0xFF bytes followed at once by eight back-to-back copies of the station's 48-bit individual address. When the frame ends, the search result is combined with three qualifiers supplied by neighbouring receive logic: the destination-address filter passed, the length is legal, and the CRC is good. If every condition holds and wake-up is enabled, the block emits a single-cycle pulse intended to set the remote wake-up interrupt status bit.

The frame boundaries come as one-cycle start and end strobes. Bytes arrive with a valid flag, so idle cycles inside a frame are allowed. CRC checking and address filtering happen elsewhere and arrive here only as flags sampled in the end-of-frame cycle. The reset input is asynchronous and active low. The block releases it internally through a two-stage synchroniser.

Top module: `wkup_detector`

## Requirements
- R1: While reset is held, and on the first end of frame after reset, `wake_pulse` is 0. A reset in the middle of a pattern discards the partial match.
- R2: A frame with six 0xFF bytes followed by eight contiguous copies of the address makes `wake_pulse` 1 in the cycle right after the `rx_eof` cycle, and only in that cycle, when `wake_en`, `da_pass`, `len_ok` and `crc_ok` are all 1.
- R3: A sync run longer than six 0xFF bytes still qualifies, because the last six 0xFF bytes before the address act as the sync.
- R4: A run of only five 0xFF bytes before the address copies gives no pulse.
- R5: The pattern may begin at any byte offset. A wrong byte inside the repetitions abandons that attempt, and a later full pattern in the same frame still qualifies. If the wrong byte is 0xFF, it counts as the first byte of a new sync run.
- R6: Only seven address copies, followed by a non-address byte, give no pulse.
- R7: With `da_pass`, `len_ok` or `crc_ok` at 0 in the `rx_eof` cycle, no pulse is issued.
- R8: With `wake_en` at 0 in the `rx_eof` cycle, no pulse is issued.
- R9: A pattern match is held only until the next `rx_sof`. A frame without the pattern that follows a matched but disqualified frame gives no pulse.
- R10: Address octets are compared first octet first, with the first octet on the wire equal to `station_addr[47:40]`. Copies sent in reversed octet order do not match.
- R11: Cycles with `rx_vld` at 0 are ignored, whatever `rx_byte` holds, and do not break contiguity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_sof | input | 1 | One-cycle strobe marking the start of a frame; it clears the match state |
| rx_vld | input | 1 | `rx_byte` carries a frame byte this cycle |
| rx_byte | input | 8 | Received byte |
| rx_eof | input | 1 | One-cycle strobe marking the end of a frame |
| station_addr | input | 48 | Station individual address; bits 47:40 are sent first |
| wake_en | input | 1 | Wake-up reporting enable |
| da_pass | input | 1 | Destination-address filter result, valid with `rx_eof` |
| len_ok | input | 1 | Legal-length result, valid with `rx_eof` |
| crc_ok | input | 1 | Good-CRC result, valid with `rx_eof` |
| wake_pulse | output | 1 | One-cycle wake-up status pulse |

## Verification
The assertions assume that `rx_eof` is a one-cycle strobe that never occurs in two cycles in a row, that `rx_sof` and `rx_eof` never fall in the same cycle, and that the address stays constant within a frame. The stimulus follows these rules. Every frame opens with a lone `rx_sof` cycle and closes with a lone `rx_eof` cycle, at least one idle cycle separates frames, and a single fixed address with no 0xFF octet is used throughout. Because that address contains no 0xFF octet, sync bytes and address bytes can never be confused, so each expected result follows directly from the byte sequence.

// File: rtl/wkd_pkg.sv
package wkd_pkg;
  localparam int unsigned OCTET_W = 8;
  typedef logic [OCTET_W-1:0] octet_t;
  localparam octet_t SYNC_OCTET = 8'hFF;
endpackage

// File: rtl/wkd_sync_run.sv
module wkd_sync_run
  import wkd_pkg::*;
#(
  parameter int unsigned SYNC_LEN = 6
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   clr,
  input  logic   take,
  input  octet_t dat,
  output logic   run_full
);
  localparam int unsigned RW = $clog2(SYNC_LEN + 1);
  localparam logic [RW-1:0] RUN_MAX = RW'(SYNC_LEN);

  logic [RW-1:0] run_q;
  logic [RW-1:0] run_b;
  logic [RW-1:0] run_d;
  logic          upd;

  assign run_b    = clr ? '0 : run_q;
  assign upd      = clr | take;
  // the run counted so far, before the current byte
  assign run_full = !clr && (run_q == RUN_MAX);

  always_comb begin
    run_d = run_b;
    if (take) begin
      if (dat == SYNC_OCTET) begin
        run_d = (run_b == RUN_MAX) ? run_b : run_b + 1'b1;
      end else begin
        run_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (upd) begin
      run_q <= run_d;
    end
  end

  AST_RUN_CAPPED: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= RUN_MAX); // R3

  AST_NON_SYNC_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
    take && (dat != SYNC_OCTET) |=> (run_q == '0)); // R4

endmodule

// File: rtl/wkd_addr_seq.sv
module wkd_addr_seq
  import wkd_pkg::*;
#(
  parameter int unsigned ADDR_OCTETS = 6,
  parameter int unsigned REPEATS     = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr,
  input  logic                         take,
  input  octet_t                       dat,
  input  logic [ADDR_OCTETS*OCTET_W-1:0] station_addr,
  input  logic                         sync_ready,
  output logic                         done
);
  localparam int unsigned OW  = $clog2(ADDR_OCTETS);
  localparam int unsigned RPW = $clog2(REPEATS);
  localparam logic [OW-1:0]  LAST_OCT = OW'(ADDR_OCTETS - 1);
  localparam logic [RPW-1:0] LAST_REP = RPW'(REPEATS - 1);

  octet_t addr_oct [ADDR_OCTETS];

  genvar g;
  generate
    for (g = 0; g < ADDR_OCTETS; g++) begin : g_oct
      assign addr_oct[g] = station_addr[(ADDR_OCTETS-g)*OCTET_W-1 -: OCTET_W];
    end
  endgenerate

  logic           act_q, act_b, act_d;
  logic [OW-1:0]  oct_q, oct_b, oct_d;
  logic [RPW-1:0] rep_q, rep_b, rep_d;
  logic           cont, start, at_last, upd;

  assign act_b   = clr ? 1'b0 : act_q;
  assign oct_b   = clr ? '0 : oct_q;
  assign rep_b   = clr ? '0 : rep_q;
  assign cont    = act_b && (dat == addr_oct[oct_b]);
  assign start   = sync_ready && (dat == addr_oct[0]);
  assign at_last = (oct_b == LAST_OCT) && (rep_b == LAST_REP);
  assign upd     = clr | take;

  always_comb begin
    act_d = act_b;
    oct_d = oct_b;
    rep_d = rep_b;
    done  = 1'b0;
    if (take) begin
      if (cont) begin
        if (at_last) begin
          act_d = 1'b0;
          oct_d = '0;
          rep_d = '0;
          done  = 1'b1;
        end else if (oct_b == LAST_OCT) begin
          oct_d = '0;
          rep_d = rep_b + 1'b1;
        end else begin
          oct_d = oct_b + 1'b1;
        end
      end else if (start) begin
        act_d = 1'b1;
        oct_d = OW'(1);
        rep_d = '0;
      end else begin
        act_d = 1'b0;
        oct_d = '0;
        rep_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      oct_q <= '0;
      rep_q <= '0;
    end else if (upd) begin
      act_q <= act_d;
      oct_q <= oct_d;
      rep_q <= rep_d;
    end
  end

  AST_OCT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, oct_q} < (OW+1)'(ADDR_OCTETS)); // R5

  AST_ENTRY_NEEDS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act_q) |-> $past(sync_ready && take)); // R4

  AST_IDLE_POSITION_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !act_q |-> (oct_q == '0) && (rep_q == '0)); // R5

endmodule

// File: rtl/wkd_frame_gate.sv
module wkd_frame_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic done,
  input  logic eof,
  input  logic wake_en,
  input  logic da_pass,
  input  logic len_ok,
  input  logic crc_ok,
  output logic hit_q,
  output logic wake_pulse
);
  logic hit_now;
  logic hit_upd;
  logic pulse_d;

  assign hit_now = (clr ? 1'b0 : hit_q) | done;
  assign hit_upd = clr | done;
  assign pulse_d = eof && hit_now && wake_en && da_pass && len_ok && crc_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q <= 1'b0;
    end else if (hit_upd) begin
      hit_q <= hit_now;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake_pulse <= 1'b0;
    end else begin
      wake_pulse <= pulse_d;
    end
  end

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |=> !wake_pulse); // R2

  AST_SOF_DROPS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    clr && !done |=> !hit_q); // R9

endmodule

// File: rtl/wkup_detector.sv
module wkup_detector
  import wkd_pkg::*;
#(
  parameter int unsigned SYNC_LEN    = 6,
  parameter int unsigned ADDR_OCTETS = 6,
  parameter int unsigned REPEATS     = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           rx_sof,
  input  logic                           rx_vld,
  input  logic [OCTET_W-1:0]             rx_byte,
  input  logic                           rx_eof,
  input  logic [ADDR_OCTETS*OCTET_W-1:0] station_addr,
  input  logic                           wake_en,
  input  logic                           da_pass,
  input  logic                           len_ok,
  input  logic                           crc_ok,
  output logic                           wake_pulse
);
  logic rst_m_q;
  logic rst_s_n;
  logic sync_ready;
  logic seq_done;
  logic hit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_s_n <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_s_n <= rst_m_q;
    end
  end

  wkd_sync_run #(.SYNC_LEN(SYNC_LEN)) run_i (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .clr      (rx_sof),
    .take     (rx_vld),
    .dat      (rx_byte),
    .run_full (sync_ready)
  );

  wkd_addr_seq #(.ADDR_OCTETS(ADDR_OCTETS), .REPEATS(REPEATS)) seq_i (
    .clk          (clk),
    .rst_n        (rst_s_n),
    .clr          (rx_sof),
    .take         (rx_vld),
    .dat          (rx_byte),
    .station_addr (station_addr),
    .sync_ready   (sync_ready),
    .done         (seq_done)
  );

  wkd_frame_gate gate_i (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .clr        (rx_sof),
    .done       (seq_done),
    .eof        (rx_eof),
    .wake_en    (wake_en),
    .da_pass    (da_pass),
    .len_ok     (len_ok),
    .crc_ok     (crc_ok),
    .hit_q      (hit_q),
    .wake_pulse (wake_pulse)
  );

  AST_PULSE_FOLLOWS_EOF: assert property (@(posedge clk) disable iff (!rst_s_n)
    wake_pulse |-> $past(rx_eof && wake_en)); // R8

  AST_PULSE_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_s_n)
    wake_pulse |-> $past(seq_done || (hit_q && !rx_sof))); // R9

  AST_PULSE_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_s_n)
    wake_pulse |-> $past(da_pass && len_ok && crc_ok)); // R7

endmodule

// File: tb/wkup_detector_tb_top.sv
module wkup_detector_tb_top;
  localparam logic [47:0] STA = 48'h021A3C4D5E6F;

  typedef struct packed {
    logic [3:0] pad;
    logic [3:0] ffs;
    logic [3:0] reps;
    logic       rev;
    logic       gap;
    logic       en;
    logic       da;
    logic       len;
    logic       crc;
    logic       exp;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{4'd0, 4'd6, 4'd8, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1}, // R2 basic
    '{4'd5, 4'd9, 4'd8, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1}, // R3 long sync, R5 offset
    '{4'd2, 4'd5, 4'd8, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0}, // R4 short sync
    '{4'd0, 4'd6, 4'd7, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0}, // R6 seven copies
    '{4'd1, 4'd6, 4'd8, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0}, // R10 reversed octets
    '{4'd0, 4'd6, 4'd8, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0}, // R7 filter fail
    '{4'd0, 4'd6, 4'd8, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0}, // R7 bad length
    '{4'd0, 4'd6, 4'd8, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0}, // R7 bad CRC
    '{4'd0, 4'd6, 4'd8, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0}, // R8 disabled
    '{4'd3, 4'd6, 4'd8, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1}  // R11 idle gaps
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        rx_sof, rx_vld, rx_eof;
  logic [7:0]  rx_byte;
  logic [47:0] station_addr;
  logic        wake_en, da_pass, len_ok, crc_ok;
  logic        wake_pulse;

  int total = 0;
  int bad   = 0;
  logic finished = 1'b0;
  logic use_gap  = 1'b0;

  always #5 clk = ~clk;

  wkup_detector dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_sof       (rx_sof),
    .rx_vld       (rx_vld),
    .rx_byte      (rx_byte),
    .rx_eof       (rx_eof),
    .station_addr (station_addr),
    .wake_en      (wake_en),
    .da_pass      (da_pass),
    .len_ok       (len_ok),
    .crc_ok       (crc_ok),
    .wake_pulse   (wake_pulse)
  );

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: wake_pulse=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic put_byte(input logic [7:0] b);
    rx_vld  = 1'b1;
    rx_byte = b;
    @(negedge clk);
    rx_vld  = 1'b0;
    if (use_gap) begin
      rx_byte = 8'hFF;
      @(negedge clk);
      rx_byte = 8'h00;
      @(negedge clk);
    end
  endtask

  task automatic put_ffs(input int n);
    for (int i = 0; i < n; i++) put_byte(8'hFF);
  endtask

  task automatic put_addr(input int reps, input logic rev);
    for (int r = 0; r < reps; r++) begin
      for (int k = 0; k < 6; k++) begin
        if (rev) put_byte(STA[8*k+7 -: 8]);
        else     put_byte(STA[47-8*k -: 8]);
      end
    end
  endtask

  task automatic open_frame();
    rx_sof = 1'b1;
    @(negedge clk);
    rx_sof = 1'b0;
  endtask

  task automatic close_frame(input logic en, input logic da, input logic ln,
                             input logic cr, input logic exp, input string req);
    put_byte(8'h11);
    put_byte(8'h22);
    check(req, wake_pulse, 1'b0);
    rx_eof = 1'b1; wake_en = en; da_pass = da; len_ok = ln; crc_ok = cr;
    @(negedge clk);
    rx_eof = 1'b0; wake_en = 1'b0; da_pass = 1'b0; len_ok = 1'b0; crc_ok = 1'b0;
    check(req, wake_pulse, exp);
    @(negedge clk);
    check(req, wake_pulse, 1'b0);
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0;
    rx_sof = 1'b0; rx_vld = 1'b0; rx_eof = 1'b0; rx_byte = 8'h00;
    station_addr = STA;
    wake_en = 1'b0; da_pass = 1'b0; len_ok = 1'b0; crc_ok = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", wake_pulse, 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: first frame after reset with junk only
    open_frame();
    put_byte(8'h33);
    close_frame(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, "R1");

    for (int v = 0; v < NV; v++) begin
      use_gap = VECS[v].gap;
      open_frame();
      for (int p = 0; p < int'(VECS[v].pad); p++) put_byte(8'h55);
      put_ffs(int'(VECS[v].ffs));
      put_addr(int'(VECS[v].reps), VECS[v].rev);
      use_gap = 1'b0;
      close_frame(VECS[v].en, VECS[v].da, VECS[v].len, VECS[v].crc,
                  VECS[v].exp, "R2-table");
    end

    // R5: broken copy, then full pattern later in the frame
    open_frame();
    put_ffs(6); put_addr(3, 1'b0); put_byte(8'h00);
    put_ffs(6); put_addr(8, 1'b0);
    close_frame(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, "R5");

    // R5: mismatching byte is 0xFF and starts the new sync run
    open_frame();
    put_ffs(6); put_addr(2, 1'b0);
    put_ffs(6); put_addr(8, 1'b0);
    close_frame(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, "R5");

    // R9: matched frame disqualified, next frame has no pattern
    open_frame();
    put_ffs(6); put_addr(8, 1'b0);
    close_frame(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R9");
    open_frame();
    put_byte(8'h44);
    close_frame(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, "R9");

    // R1: reset in the middle of a pattern discards it
    open_frame();
    put_ffs(6); put_addr(4, 1'b0);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", wake_pulse, 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    put_addr(4, 1'b0);
    close_frame(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, "R1");

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule